// File: doc/BRIEF.md
# HDLC Transmit Flag Sequencer

This block turns a stream of octets into a bit-serial HDLC line signal, one line bit per clock. Octets arrive on a valid/ready interface with an end-of-frame marker. Each frame is wrapped in flags (pattern 0x7E). Its data bits go out least significant bit first, followed by a frame check sequence (FCS) of 16 or 32 bits. Zero-bit insertion ("stuffing") keeps the flag pattern from appearing inside a frame. When nothing is pending, the line carries an unbroken run of flags.

A 4-bit input sets the least number of idle flags that must separate frames, and also the idle flags sent ahead of the first frame after reset. Software may change this count while traffic is running. A change takes hold at the next inter-frame gap and never inside the gap already being timed. A count of zero still keeps a closing flag and a separate opening flag between back-to-back frames. The source is expected to offer each byte of a frame when asked. If it does not, the block ends the frame at that point and appends the FCS.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While `rst_n` is low, `tx_bit` and `in_ready` are 0. With no frame pending, the line repeats the flag bits 0,1,1,1,1,1,1,0 in that order.
- R2: Between a frame's closing flag and the next frame's opening flag, exactly `flag_min` idle flags are sent when the next frame is already waiting. A count of 0 gives a closing flag followed at once by a separate opening flag. After reset, `flag_min` flags come before the first opening flag.
- R3: `flag_min` is captured when a frame's last FCS bit is sent, and that value governs the following gap. A change made while a frame is in flight affects only the gap after it. Before the first frame after reset, the live value is used.
- R4: Each accepted byte is sent bit 0 first. The first byte of a frame is taken during the last bit of its opening flag.
- R5: After five consecutive 1 bits of data or FCS, one 0 bit is inserted. The run count restarts at each flag. A zero owed after the final FCS bit is sent before the closing flag. Flag bits are never stuffed.
- R6: `crc_wide` = 0 selects the 16-bit FCS with polynomial 0x1021 (x^16+x^12+x^5+1). `crc_wide` = 1 selects the 32-bit FCS with polynomial 0x04C11DB7. The select is captured with the first byte of each frame.
- R7: The FCS register is preset to all ones and is fed the data bits in line order, shifting left with feedback from the msb. The complement of the final register is sent msb first.
- R8: A byte moves when `in_valid` and `in_ready` are both 1 at a clock edge. `in_ready` is 1 only in a cycle that sends the last bit of the byte shift register, or the last bit of an opening flag, and never in a cycle that sends an inserted zero.
- R9: The byte accepted with `in_last` = 1 ends the frame, and the FCS follows its last bit directly. `in_ready` stays 0 until the next opening flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flag_min | input | 4 | Minimum idle flag count between frames |
| crc_wide | input | 1 | FCS select: 0 = 16 bit, 1 = 32 bit |
| in_valid | input | 1 | Source offers a byte |
| in_data | input | 8 | Offered byte |
| in_last | input | 1 | Offered byte is the final byte of its frame |
| in_ready | output | 1 | Block takes the offered byte at this edge |
| tx_bit | output | 1 | Serial line output |

## Verification
Nearly every wrong internal state surfaces on `tx_bit` within one octet time. A bad bit index or shift register corrupts the very next data bit. A lost or extra stuffing zero shifts the whole remainder of the frame by one bit, so every later comparison fails. A wrong flag-gap counter adds or removes eight-bit flags and misplaces the whole following frame. An FCS fault shows up only in the 16 or 32 FCS bits, which is why frames with both widths and with runs of ones that force stuffing inside the FCS are compared bit for bit against an independently computed stream.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
   typedef enum logic [1:0] {
      ST_FLAG = 2'd0,
      ST_DATA = 2'd1,
      ST_FCS  = 2'd2
   } tx_state_e;

   localparam logic [7:0]  FLAG_PATTERN = 8'h7E;
   localparam logic [31:0] POLY_16      = 32'h0000_1021;
   localparam logic [31:0] POLY_32      = 32'h04C1_1DB7;
   localparam int          STUFF_RUN    = 5;
   localparam int          FLAG_BITS    = 8;
endpackage

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs #(
   parameter int          W    = 16,
   parameter logic [31:0] POLY = 32'h0000_1021
) (
   input  logic clk,
   input  logic rst_n,
   input  logic preset,
   input  logic step,
   input  logic din,
   input  logic shift,
   output logic bit_out
);
   if (W < 2 || W > 32) begin : g_bad_width
      $error("hdlc_tx_fcs: W must be within 2..32");
   end

   localparam logic [W-1:0] P = POLY[W-1:0];

   logic [W-1:0] rem;
   logic         fb;

   assign fb      = rem[W-1] ^ din;
   assign bit_out = ~rem[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem <= '1;
      end else if (preset) begin
         rem <= '1;
      end else if (step) begin
         rem <= {rem[W-2:0], 1'b0} ^ (fb ? P : '0);
      end else if (shift) begin
         rem <= {rem[W-2:0], 1'b1};
      end
   end
endmodule

// File: rtl/hdlc_tx_stuffer.sv
module hdlc_tx_stuffer #(
   parameter int RUN = hdlc_tx_pkg::STUFF_RUN
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stuffable,
   input  logic src_bit,
   output logic stuff_q
);
   if (RUN < 1) begin : g_bad_run
      $error("hdlc_tx_stuffer: RUN must be positive");
   end

   localparam int CNT_W = $clog2(RUN + 1);

   logic [CNT_W-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         stuff_q <= 1'b0;
      end else if (stuff_q) begin
         run_cnt <= '0;
         stuff_q <= 1'b0;
      end else if (!stuffable || !src_bit) begin
         run_cnt <= '0;
      end else if (run_cnt == CNT_W'(RUN - 1)) begin
         run_cnt <= '0;
         stuff_q <= 1'b1;
      end else begin
         run_cnt <= run_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
   import hdlc_tx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int FLAG_CNT_W = 4,
   parameter bit FCS32_EN   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [FLAG_CNT_W-1:0] flag_min,
   input  logic                  crc_wide,
   input  logic                  in_valid,
   input  logic [DATA_W-1:0]     in_data,
   input  logic                  in_last,
   output logic                  in_ready,
   input  logic                  stuff_q,
   input  logic                  fcs_bit,
   output logic                  src_bit,
   output logic                  stuffable,
   output logic                  fcs_preset,
   output logic                  fcs_step,
   output logic                  fcs_shift,
   output logic                  sel_q,
   output tx_state_e             cur_st,
   output logic [FLAG_CNT_W-1:0] nof_q
);
   localparam int IDX_W = 6;
   localparam int GAP_W = FLAG_CNT_W + 1;
   localparam int CMP_W = GAP_W + 1;

   tx_state_e              st;
   logic [IDX_W-1:0]       idx;
   logic [DATA_W-1:0]      shreg;
   logic                   last_q;
   logic                   first_q;
   logic [GAP_W-1:0]       gap_cnt;
   logic [GAP_W-1:0]       gap_inc;
   logic [FLAG_CNT_W-1:0]  eff_nof;
   logic                   adv;
   logic                   open_ok;
   logic                   flag_end;
   logic                   data_end;
   logic                   fcs_end;
   logic [IDX_W-1:0]       fcs_last_idx;
   logic                   take;

   assign adv          = !stuff_q;
   assign gap_inc      = (gap_cnt == '1) ? gap_cnt : gap_cnt + 1'b1;
   assign eff_nof      = first_q ? flag_min : nof_q;
   assign open_ok      = ({1'b0, gap_inc} >= ({2'b00, eff_nof} + CMP_W'(2)));
   assign fcs_last_idx = sel_q ? IDX_W'(31) : IDX_W'(15);
   assign flag_end     = (st == ST_FLAG) && (idx == IDX_W'(FLAG_BITS - 1));
   assign data_end     = (st == ST_DATA) && (idx == IDX_W'(DATA_W - 1));
   assign fcs_end      = (st == ST_FCS)  && (idx == fcs_last_idx);
   assign in_ready     = adv && ((flag_end && open_ok) || (data_end && !last_q));
   assign take         = in_ready && in_valid;

   assign stuffable  = (st != ST_FLAG);
   assign fcs_preset = take && (st == ST_FLAG);
   assign fcs_step   = adv && (st == ST_DATA);
   assign fcs_shift  = adv && (st == ST_FCS);
   assign cur_st     = st;

   always_comb begin
      unique case (st)
         ST_FLAG: src_bit = FLAG_PATTERN[idx[2:0]];
         ST_DATA: src_bit = shreg[0];
         default: src_bit = fcs_bit;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_FLAG;
         idx     <= '0;
         shreg   <= '0;
         last_q  <= 1'b0;
         first_q <= 1'b1;
         gap_cnt <= GAP_W'(1);
         nof_q   <= '0;
         sel_q   <= 1'b0;
      end else if (adv) begin
         unique case (st)
            ST_FLAG: begin
               if (flag_end) begin
                  idx     <= '0;
                  gap_cnt <= gap_inc;
                  if (take) begin
                     st      <= ST_DATA;
                     shreg   <= in_data;
                     last_q  <= in_last;
                     first_q <= 1'b0;
                     sel_q   <= crc_wide & FCS32_EN;
                  end
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_DATA: begin
               if (data_end) begin
                  idx <= '0;
                  if (take) begin
                     shreg  <= in_data;
                     last_q <= in_last;
                  end else begin
                     st <= ST_FCS;
                  end
               end else begin
                  idx   <= idx + 1'b1;
                  shreg <= shreg >> 1;
               end
            end
            default: begin
               if (fcs_end) begin
                  st      <= ST_FLAG;
                  idx     <= '0;
                  gap_cnt <= '0;
                  nof_q   <= flag_min;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
   import hdlc_tx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int FLAG_CNT_W = 4,
   parameter bit FCS32_EN   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [FLAG_CNT_W-1:0] flag_min,
   input  logic                  crc_wide,
   input  logic                  in_valid,
   input  logic [DATA_W-1:0]     in_data,
   input  logic                  in_last,
   output logic                  in_ready,
   output logic                  tx_bit
);
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data_w
      $error("hdlc_tx_framer: DATA_W must be within 1..32");
   end
   if (FLAG_CNT_W < 1 || FLAG_CNT_W > 8) begin : g_bad_flag_w
      $error("hdlc_tx_framer: FLAG_CNT_W must be within 1..8");
   end

   logic                  stuff_q;
   logic                  src_bit;
   logic                  stuffable;
   logic                  fcs_preset;
   logic                  fcs_step;
   logic                  fcs_shift;
   logic                  fcs_bit;
   logic                  c16_bit;
   logic                  sel_q;
   tx_state_e             cur_st;
   logic [FLAG_CNT_W-1:0] nof_q;

   hdlc_tx_ctrl #(
      .DATA_W     (DATA_W),
      .FLAG_CNT_W (FLAG_CNT_W),
      .FCS32_EN   (FCS32_EN)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .flag_min   (flag_min),
      .crc_wide   (crc_wide),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .in_last    (in_last),
      .in_ready   (in_ready),
      .stuff_q    (stuff_q),
      .fcs_bit    (fcs_bit),
      .src_bit    (src_bit),
      .stuffable  (stuffable),
      .fcs_preset (fcs_preset),
      .fcs_step   (fcs_step),
      .fcs_shift  (fcs_shift),
      .sel_q      (sel_q),
      .cur_st     (cur_st),
      .nof_q      (nof_q)
   );

   hdlc_tx_stuffer #(.RUN(STUFF_RUN)) u_stuff (
      .clk       (clk),
      .rst_n     (rst_n),
      .stuffable (stuffable),
      .src_bit   (src_bit),
      .stuff_q   (stuff_q)
   );

   hdlc_tx_fcs #(.W(16), .POLY(POLY_16)) u_fcs16 (
      .clk     (clk),
      .rst_n   (rst_n),
      .preset  (fcs_preset),
      .step    (fcs_step),
      .din     (src_bit),
      .shift   (fcs_shift),
      .bit_out (c16_bit)
   );

   if (FCS32_EN) begin : g_fcs32
      logic c32_bit;
      hdlc_tx_fcs #(.W(32), .POLY(POLY_32)) u_fcs32 (
         .clk     (clk),
         .rst_n   (rst_n),
         .preset  (fcs_preset),
         .step    (fcs_step),
         .din     (src_bit),
         .shift   (fcs_shift),
         .bit_out (c32_bit)
      );
      assign fcs_bit = sel_q ? c32_bit : c16_bit;
   end else begin : g_fcs16_only
      assign fcs_bit = c16_bit;
   end

   assign tx_bit = stuff_q ? 1'b0 : src_bit;
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk
   import hdlc_tx_pkg::*;
#(
   parameter int FLAG_CNT_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tx_bit,
   input  logic                  in_valid,
   input  logic                  in_ready,
   input  logic                  in_last,
   input  logic                  stuff_q,
   input  logic                  sel_q,
   input  tx_state_e             cur_st,
   input  logic [FLAG_CNT_W-1:0] nof_q
);
   logic [2:0] ones_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_run <= '0;
      end else if (!tx_bit) begin
         ones_run <= '0;
      end else if (ones_run != 3'd7) begin
         ones_run <= ones_run + 1'b1;
      end
   end

   // R5: no line run of ones longer than the six inside a flag
   assert_ones_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ones_run <= 3'd6);

   // R8: never ready while an inserted zero is on the line
   assert_ready_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !stuff_q);

   // R9: after the final byte, the next cycle is not ready
   assert_last_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> !in_ready);

   // R3: captured flag count is frozen while a frame is in flight
   assert_nof_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_st != ST_FLAG) |-> $stable(nof_q));

   // R6: FCS width select does not move while the FCS is sent
   assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_st == ST_FCS) |-> $stable(sel_q));
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk #(.FLAG_CNT_W(FLAG_CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_bit   (tx_bit),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .in_last  (in_last),
   .stuff_q  (stuff_q),
   .sel_q    (sel_q),
   .cur_st   (cur_st),
   .nof_q    (nof_q)
);

// File: tb/sim_hdlc_tx_framer.sv
module sim_hdlc_tx_framer;
   localparam int NF = 5;
   localparam int NB = 12;

   logic       clk      = 1'b0;
   logic       rst_n    = 1'b0;
   logic [3:0] flag_min = 4'd2;
   logic       crc_wide = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data  = 8'h00;
   logic       in_last  = 1'b0;
   logic       in_ready;
   logic       tx_bit;

   logic [7:0] fbytes [0:NB-1] = '{8'h55, 8'hA3, 8'h0F, 8'hFF, 8'hFF, 8'h7E,
                                   8'hF8, 8'h1F, 8'h3E, 8'h00, 8'hFF, 8'h01};
   int flen [0:NF-1] = '{3, 2, 1, 4, 2};
   int foff [0:NF-1] = '{0, 3, 5, 6, 10};
   int fgap [0:NF-1] = '{2, 0, 3, 1, 0};
   bit fw   [0:NF-1] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

   bit    exp_q[$];
   string tag_q[$];
   int    ones;
   int    n_chk  = 0;
   int    n_fail = 0;
   int    cyc    = 0;
   int    cur_f  = 0;
   int    cur_b  = 0;
   int    n_acc  = 0;
   bit    took   = 1'b0;

   hdlc_tx_framer u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .flag_min (flag_min),
      .crc_wide (crc_wide),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_last  (in_last),
      .in_ready (in_ready),
      .tx_bit   (tx_bit)
   );

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic push_flag(input string tag);
      for (int i = 0; i < 8; i++) begin
         exp_q.push_back(i != 0 && i != 7);
         tag_q.push_back(tag);
      end
   endtask

   task automatic push_stuffed(input bit b, input string tag);
      exp_q.push_back(b);
      tag_q.push_back(tag);
      if (b) begin
         ones++;
         if (ones == 5) begin
            exp_q.push_back(1'b0);
            tag_q.push_back("R5 inserted zero");
            ones = 0;
         end
      end else begin
         ones = 0;
      end
   endtask

   // driver side of the scoreboard: expected line bits of one frame
   task automatic push_frame(input int f);
      logic [31:0] crc;
      logic [31:0] poly;
      logic [31:0] mask;
      int          w;
      bit          b;
      bit          fb;
      for (int g = 0; g <= fgap[f]; g++) push_flag("R2 R3 gap/opening flag");
      ones = 0;
      w    = fw[f] ? 32 : 16;
      poly = fw[f] ? 32'h04C1_1DB7 : 32'h0000_1021;
      mask = fw[f] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      crc  = mask;
      for (int k = 0; k < flen[f]; k++) begin
         for (int i = 0; i < 8; i++) begin
            b  = fbytes[foff[f] + k][i];
            push_stuffed(b, "R4 data lsb-first");
            fb = crc[w-1] ^ b;
            crc = ((crc << 1) ^ (fb ? poly : 32'h0)) & mask;
         end
      end
      for (int i = w - 1; i >= 0; i--) push_stuffed(~crc[i], "R6 R7 fcs");
      push_flag("R2 R9 closing flag");
   endtask

   initial begin
      for (int f = 0; f < NF; f++) push_frame(f);
      for (int i = 0; i < 3; i++) push_flag("R1 idle flag");
   end

   always @(negedge clk) begin
      cyc++;
      if (cyc < 4) begin
         if (cyc == 3) begin
            chk(tx_bit == 1'b0, "R1 tx_bit in reset", int'(tx_bit), 0);
            chk(in_ready == 1'b0, "R1 R8 in_ready in reset", int'(in_ready), 0);
         end
      end else begin
         if (cyc == 4) rst_n = 1'b1;
         // byte accepted at the last rising edge
         if (took) begin
            n_acc++;
            if (cur_b == 0 && cur_f + 1 < NF) begin
               flag_min = 4'(fgap[cur_f + 1]);
               crc_wide = fw[cur_f + 1];
            end
            if (cur_b == flen[cur_f] - 1) begin
               cur_f++;
               cur_b = 0;
            end else begin
               cur_b++;
            end
         end
         if (cur_f < NF) begin
            in_valid = 1'b1;
            in_data  = fbytes[foff[cur_f] + cur_b];
            in_last  = (cur_b == flen[cur_f] - 1);
         end else begin
            in_valid = 1'b0;
            in_data  = 8'h00;
            in_last  = 1'b0;
         end
         took = in_valid && in_ready;
         // monitor side of the scoreboard
         if (exp_q.size() == 0) begin
            chk(cur_f == NF, "R9 all frames closed", cur_f, NF);
            chk(n_acc == NB, "R8 bytes accepted", n_acc, NB);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
         end else begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(tx_bit == e, t, int'(tx_bit), int'(e));
         end
      end
      if (cyc > 20000) begin
         chk(1'b0, "R1 watchdog expired", cyc, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule